// File: doc/BRIEF.md
# MSI Mask-Clear Watch and Status

This block holds a 32-bit MSI mask for each of 32 functions and watches every write to those masks. Functions 0 to 3 are the physical functions and functions 4 to 31 are virtual functions 0 to 27. One write port carries a function index and a new mask value. Firmware and the host share that port. On each write, the block compares the stored mask with the incoming value. If any bit goes from 1 to 0, and the detection enable input is high, the block sets that function's bit in a 32-bit sticky status register.

Firmware clears status bits by writing ones to them. The status bits, gated by a per-bit interrupt mask, are ORed into one level-sensitive local interrupt. Both the status word and any function's stored mask can be read back combinationally through a small read port.

Top module: `msiClearWatch`

## Requirements
- R1: Status bit i belongs to function i: bits 0..3 are physical functions 0..3 and bits 4..31 are virtual functions 0..27. The read port with rdStatusSel=0 and rdIdx=i returns function i's stored mask.
- R2: After reset, every status bit is 0, localIrq is 0, and every stored mask is all ones (0xFFFFFFFF).
- R3: A write with maskWrEn=1 and maskWrIdx below 32, while detectEn=1, sets status bit maskWrIdx at that clock edge if (stored AND NOT new) is nonzero. The stored mask takes the new value at the same edge.
- R4: While detectEn=0, a mask write never sets a status bit. The stored mask is still updated.
- R5: At a clock edge with stsClrEn=1, each status bit whose stsClrData bit is 1 is cleared. A 0 in stsClrData leaves its bit unchanged.
- R6: A set status bit stays set until a write-one-to-clear reaches it.
- R7: A write that only turns bits from 0 to 1, or that rewrites the stored value, does not set the status bit.
- R8: localIrq is 1 exactly when some status bit is 1 while its intMask bit is 0. An intMask bit of 1 masks its status bit.
- R9: A mask write with maskWrIdx of 32 or more changes no stored mask and no status bit. A read with such an rdIdx returns 0.
- R10: If a set (R3) and a clear (R5) reach the same status bit at the same edge, the bit ends up 1.
- R11: With rdStatusSel=1, rdData shows the current status word with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| maskWrEn | input | 1 | Mask write strobe |
| maskWrIdx | input | 6 | Function index of the mask write |
| maskWrData | input | 32 | New mask value |
| detectEn | input | 1 | Enables setting status on a 1-to-0 change |
| stsClrEn | input | 1 | Write-one-to-clear strobe for status |
| stsClrData | input | 32 | Bits to clear (1 clears) |
| intMask | input | 32 | Per-status-bit interrupt mask (1 masks) |
| rdStatusSel | input | 1 | 1 selects the status word, 0 selects a mask |
| rdIdx | input | 6 | Function index for mask read-back |
| rdData | output | 32 | Read-back data |
| localIrq | output | 1 | Level-sensitive local interrupt |

## Verification
The assertions assume that maskWrEn and stsClrEn are synchronous single-cycle strobes. They also assume that maskWrIdx and stsClrData are valid whenever their strobe is high, and that detectEn changes only between clock edges. The bench changes every input on the falling edge and holds it across the next rising edge, so each write or clear is seen at exactly one edge. Out-of-range indices, simultaneous set and clear, and changes of detectEn are driven on purpose. They stay inside these assumptions.

// File: rtl/msiClrPkg.sv
package msiClrPkg;
  localparam int NUM_FN = 32;
  localparam int MASK_W = 32;
  localparam int FN_W   = $clog2(NUM_FN);
  localparam int IDX_W  = FN_W + 1;

  typedef struct packed {
    logic            wrValid;
    logic [FN_W-1:0] wrFn;
  } wrStrobe_t;
endpackage

// File: rtl/msiClrCtrl.sv
module msiClrCtrl
  import msiClrPkg::*;
#(
  parameter int NUM_FNS = NUM_FN,
  parameter int IDX_WD  = IDX_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               maskWrEn,
  input  logic [IDX_WD-1:0]  maskWrIdx,
  input  logic               detectEn,
  input  logic               stsClrEn,
  input  logic [NUM_FNS-1:0] stsClrData,
  input  logic [NUM_FNS-1:0] intMask,
  input  logic               dropHit,
  output wrStrobe_t          strobe,
  output logic [NUM_FNS-1:0] stsOut,
  output logic               irqOut
);
  localparam int FNW = $clog2(NUM_FNS);

  logic               idxOk;
  logic [NUM_FNS-1:0] setVec;
  logic [NUM_FNS-1:0] clrVec;
  logic [NUM_FNS-1:0] stsNext;
  logic [NUM_FNS-1:0] stsQ;

  // Out-of-range indices never reach the datapath.
  assign idxOk          = (maskWrIdx < IDX_WD'(NUM_FNS));
  assign strobe.wrValid = maskWrEn && idxOk;
  assign strobe.wrFn    = FN_W'(maskWrIdx[FNW-1:0]);

  always_comb begin
    setVec = '0;
    if (strobe.wrValid && detectEn && dropHit)
      setVec = NUM_FNS'(1) << maskWrIdx[FNW-1:0];
    clrVec  = stsClrEn ? stsClrData : '0;
    // The set is applied after the clear, so a set wins.
    stsNext = (stsQ & ~clrVec) | setVec;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stsQ <= '0;
    else       stsQ <= stsNext;
  end

  assign stsOut = stsQ;
  assign irqOut = |(stsQ & ~intMask);
endmodule

// File: rtl/msiClrData.sv
module msiClrData
  import msiClrPkg::*;
#(
  parameter int NUM_FNS = NUM_FN,
  parameter int MASK_WD = MASK_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  wrStrobe_t          strobe,
  input  logic [MASK_WD-1:0] wrData,
  output logic               dropHit,
  output logic [MASK_WD-1:0] maskArr [NUM_FNS]
);
  logic [MASK_WD-1:0] oldMask;

  genvar g;
  generate
    for (g = 0; g < NUM_FNS; g++) begin : gMask
      logic [MASK_WD-1:0] maskQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)
          maskQ <= '1;
        else if (strobe.wrValid && (strobe.wrFn == FN_W'(g)))
          maskQ <= wrData;
      end
      assign maskArr[g] = maskQ;
    end
  endgenerate

  assign oldMask = maskArr[strobe.wrFn];
  // Any bit that is 1 now and 0 in the new value counts as a drop.
  assign dropHit = strobe.wrValid && (|(oldMask & ~wrData));
endmodule

// File: rtl/msiClrRead.sv
module msiClrRead
  import msiClrPkg::*;
#(
  parameter int NUM_FNS = NUM_FN,
  parameter int MASK_WD = MASK_W,
  parameter int IDX_WD  = IDX_W
) (
  input  logic               rdStatusSel,
  input  logic [IDX_WD-1:0]  rdIdx,
  input  logic [NUM_FNS-1:0] sts,
  input  logic [MASK_WD-1:0] maskArr [NUM_FNS],
  output logic [MASK_WD-1:0] rdData
);
  localparam int FNW = $clog2(NUM_FNS);

  always_comb begin
    if (rdStatusSel)
      rdData = MASK_WD'(sts);
    else if (rdIdx < IDX_WD'(NUM_FNS))
      rdData = maskArr[rdIdx[FNW-1:0]];
    else
      rdData = '0;
  end
endmodule

// File: rtl/msiClearWatch.sv
module msiClearWatch
  import msiClrPkg::*;
#(
  parameter int NUM_FNS = NUM_FN,
  parameter int MASK_WD = MASK_W,
  parameter int IDX_WD  = IDX_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               maskWrEn,
  input  logic [IDX_WD-1:0]  maskWrIdx,
  input  logic [MASK_WD-1:0] maskWrData,
  input  logic               detectEn,
  input  logic               stsClrEn,
  input  logic [NUM_FNS-1:0] stsClrData,
  input  logic [NUM_FNS-1:0] intMask,
  input  logic               rdStatusSel,
  input  logic [IDX_WD-1:0]  rdIdx,
  output logic [MASK_WD-1:0] rdData,
  output logic               localIrq
);
  wrStrobe_t          strobe;
  logic               dropHit;
  logic [NUM_FNS-1:0] stsReg;
  logic [MASK_WD-1:0] maskArr [NUM_FNS];

  msiClrCtrl #(.NUM_FNS(NUM_FNS), .IDX_WD(IDX_WD)) u_ctrl (
    .clk(clk), .rstN(rstN), .maskWrEn(maskWrEn), .maskWrIdx(maskWrIdx),
    .detectEn(detectEn), .stsClrEn(stsClrEn), .stsClrData(stsClrData),
    .intMask(intMask), .dropHit(dropHit), .strobe(strobe),
    .stsOut(stsReg), .irqOut(localIrq)
  );

  msiClrData #(.NUM_FNS(NUM_FNS), .MASK_WD(MASK_WD)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(maskWrData),
    .dropHit(dropHit), .maskArr(maskArr)
  );

  msiClrRead #(.NUM_FNS(NUM_FNS), .MASK_WD(MASK_WD), .IDX_WD(IDX_WD)) u_read (
    .rdStatusSel(rdStatusSel), .rdIdx(rdIdx), .sts(stsReg),
    .maskArr(maskArr), .rdData(rdData)
  );
endmodule

// File: rtl/msiClearWatchChk.sv
module msiClearWatchChk
  import msiClrPkg::*;
#(
  parameter int NUM_FNS = NUM_FN,
  parameter int IDX_WD  = IDX_W
) (
  input logic               clk,
  input logic               rstN,
  input logic               maskWrEn,
  input logic [IDX_WD-1:0]  maskWrIdx,
  input logic               detectEn,
  input logic               stsClrEn,
  input logic [NUM_FNS-1:0] stsClrData,
  input logic [NUM_FNS-1:0] intMask,
  input logic               localIrq,
  input logic [NUM_FNS-1:0] stsReg
);
  assert_masked_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    (&intMask) |-> !localIrq);

  assert_disabled_no_set_R4: assert property (@(posedge clk) disable iff (!rstN)
    !detectEn |=> ((stsReg & ~$past(stsReg)) == '0));

  assert_bad_index_no_set_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!maskWrEn || (maskWrIdx >= IDX_WD'(NUM_FNS))) |=> ((stsReg & ~$past(stsReg)) == '0));

  assert_w1c_clears_R5: assert property (@(posedge clk) disable iff (!rstN)
    (stsClrEn && !maskWrEn) |=> ((stsReg & $past(stsClrData)) == '0));

  assert_sticky_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !stsClrEn |=> (($past(stsReg) & ~stsReg) == '0));

  assert_single_set_R3: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> $countones(stsReg & ~$past(stsReg)) <= 1);
endmodule

bind msiClearWatch msiClearWatchChk #(.NUM_FNS(NUM_FNS), .IDX_WD(IDX_WD)) u_chk (
  .clk(clk), .rstN(rstN), .maskWrEn(maskWrEn), .maskWrIdx(maskWrIdx),
  .detectEn(detectEn), .stsClrEn(stsClrEn), .stsClrData(stsClrData),
  .intMask(intMask), .localIrq(localIrq), .stsReg(stsReg)
);

// File: tb/test_msiClearWatch.sv
module test_msiClearWatch;
  localparam int CLK_PERIOD = 10;
  localparam int NF = 32;
  localparam int WATCHDOG = 100000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        maskWrEn = 1'b0;
  logic [5:0]  maskWrIdx = '0;
  logic [31:0] maskWrData = '0;
  logic        detectEn = 1'b0;
  logic        stsClrEn = 1'b0;
  logic [31:0] stsClrData = '0;
  logic [31:0] intMask = '0;
  logic        rdStatusSel = 1'b0;
  logic [5:0]  rdIdx = '0;
  logic [31:0] rdData;
  logic        localIrq;

  msiClearWatch i_msiClearWatch (
    .clk(clk), .rstN(rstN), .maskWrEn(maskWrEn), .maskWrIdx(maskWrIdx),
    .maskWrData(maskWrData), .detectEn(detectEn), .stsClrEn(stsClrEn),
    .stsClrData(stsClrData), .intMask(intMask), .rdStatusSel(rdStatusSel),
    .rdIdx(rdIdx), .rdData(rdData), .localIrq(localIrq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic        isIrq;
    logic [31:0] exp;
    int          req;
  } item_t;

  item_t       sbQ[$];
  int          nVec = 0;
  int          nBad = 0;
  int          cycles = 0;
  bit          done = 1'b0;
  logic [31:0] refMask [NF];
  logic [31:0] refSts;

  // Monitor: pops expected items and compares them with the ports.
  initial begin
    forever begin
      item_t it;
      wait (sbQ.size() > 0);
      it = sbQ.pop_front();
      nVec++;
      if (it.isIrq) begin
        if (localIrq !== it.exp[0]) begin
          nBad++;
          $display("FAIL R%0d localIrq actual=%0b expected=%0b", it.req, localIrq, it.exp[0]);
        end
      end else if (rdData !== it.exp) begin
        nBad++;
        $display("FAIL R%0d rdData actual=%08h expected=%08h", it.req, rdData, it.exp);
      end
    end
  end

  task automatic pushItem(input logic irq, input logic [31:0] e, input int r);
    item_t it;
    it.isIrq = irq; it.exp = e; it.req = r;
    sbQ.push_back(it);
    wait (sbQ.size() == 0);
  endtask

  task automatic chkMask(input logic [5:0] idx, input int r);
    logic [31:0] e;
    rdStatusSel = 1'b0; rdIdx = idx; #1;
    e = (idx < 6'(NF)) ? refMask[idx[4:0]] : 32'h0;
    pushItem(1'b0, e, r);
  endtask

  task automatic chkSts(input int r);
    rdStatusSel = 1'b1; #1;
    pushItem(1'b0, refSts, r);
  endtask

  task automatic chkIrq(input int r);
    #1;
    pushItem(1'b1, {31'b0, |(refSts & ~intMask)}, r);
  endtask

  // Driver: one clock edge with an optional mask write and optional clear.
  task automatic step(input logic we, input logic [5:0] idx, input logic [31:0] d,
                      input logic ce, input logic [31:0] cd);
    logic [31:0] setV;
    @(negedge clk);
    maskWrEn = we; maskWrIdx = idx; maskWrData = d;
    stsClrEn = ce; stsClrData = cd;
    @(posedge clk);
    setV = '0;
    if (we && idx < 6'(NF)) begin
      if (detectEn && |(refMask[idx[4:0]] & ~d)) setV[idx[4:0]] = 1'b1;
      refMask[idx[4:0]] = d;
    end
    if (ce) refSts = refSts & ~cd;
    refSts = refSts | setV;
    @(negedge clk);
    maskWrEn = 1'b0; stsClrEn = 1'b0;
  endtask

  initial begin
    while (!done && cycles < WATCHDOG) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      nBad++; nVec++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      $display("  == %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NF; i++) refMask[i] = '1;
    refSts = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;

    // R2 reset state
    chkSts(2); chkIrq(2); chkMask(6'd0, 2); chkMask(6'd31, 2);

    detectEn = 1'b1;
    // R3 / R1 physical function 0, single bit drop
    step(1'b1, 6'd0, 32'hFFFF_FFFE, 1'b0, '0);
    chkSts(3); chkIrq(8); chkMask(6'd0, 3);
    // R1 virtual function 0 is bit 4, last virtual function is bit 31
    step(1'b1, 6'd4, 32'h0, 1'b0, '0);
    chkSts(1);
    step(1'b1, 6'd31, 32'h7FFF_FFFF, 1'b0, '0);
    chkSts(1); chkMask(6'd31, 1);
    // R7 same value and 0->1 only
    step(1'b1, 6'd5, 32'hFFFF_FFFF, 1'b0, '0);
    chkSts(7);
    step(1'b1, 6'd4, 32'h0000_00F0, 1'b0, '0);
    chkSts(7);
    // R6 hold over idle cycles
    repeat (5) step(1'b0, 6'd0, '0, 1'b0, '0);
    chkSts(6);
    // R5 clear bit 0 only, then a clear of zeros
    step(1'b0, 6'd0, '0, 1'b1, 32'h0000_0001);
    chkSts(5);
    step(1'b0, 6'd0, '0, 1'b1, 32'h0);
    chkSts(5);
    // R8 masking
    @(negedge clk); intMask = refSts; chkIrq(8);
    @(negedge clk); intMask = refSts & ~32'h10; chkIrq(8);
    @(negedge clk); intMask = '0;
    // R4 detection disabled: no set, mask still written
    detectEn = 1'b0;
    step(1'b1, 6'd10, 32'h0, 1'b0, '0);
    chkSts(4); chkMask(6'd10, 4);
    detectEn = 1'b1;
    // R9 out-of-range index
    step(1'b1, 6'd40, 32'h0, 1'b0, '0);
    chkSts(9); chkMask(6'd40, 9); chkMask(6'd8, 9);
    // R10 set and clear on the same bit at the same edge
    step(1'b1, 6'd1, 32'hFFFF_00FF, 1'b1, 32'h0000_0002);
    chkSts(10);
    // R11 status is visible without delay after a clear
    step(1'b0, 6'd0, '0, 1'b1, 32'hFFFF_FFFF);
    chkSts(11); chkIrq(8);
    // Mixed traffic against the model (R3 R5 R7 R8)
    for (int k = 0; k < 300; k++) begin
      logic [5:0]  ix = 6'($urandom_range(0, 35));
      logic [31:0] dv = $urandom();
      detectEn = ($urandom_range(0, 7) != 0);
      intMask = $urandom();
      step(1'b1, ix, dv, ($urandom_range(0, 3) == 0), $urandom());
      chkSts(3); chkIrq(8);
      if (k % 10 == 0) chkMask(ix, 3);
    end

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule